// File: doc/BRIEF.md
# CAN frame field parser

This block sits behind a bit destuffer on the receive side of a CAN node. Each destuffed frame bit arrives on `bit_val` with a one-cycle strobe on `bit_vld`. The block counts bits from start of frame and works out which field each bit belongs to. At the IDE bit it switches between the standard and the extended layout.

The block collects the following fields:
- the base and extended identifiers, and the combined 29-bit identifier;
- the IDE and RTR flags;
- the data length code;
- up to eight data bytes;
- the received CRC sequence;
- the ACK slot.

It also keeps sticky warnings for malformed fixed-form bits. The position of the last data bit is computed from the DLC and the frame type as soon as the DLC is complete. That position is reported on `last_pos`, so the destuffer knows where stuffing stops. A single-cycle `frame_done` pulse marks the end of the frame. After that, every field holds its value until the next start-of-frame bit arrives.

Top module: `can_field_parser`

## Requirements
- R1: After reset all field outputs, `warn` and `frame_done` are zero, and `last_pos` reads 127.
- R2: Frame bits 1..11 are shifted MSB first into `base_id`. `warn[1]` is set when `base_id[10:4]` are all ones.
- R3: Bit 13 is the IDE bit, with 1 meaning extended, and it sets `ide`. In a standard frame `rtr` takes bit 12. In an extended frame bit 12 is the SRR bit and `rtr` takes bit 32.
- R4: In an extended frame, bits 14..31 go MSB first into `ext_id`. `full_id` equals `{base_id, ext_id}`, and `ext_id` stays zero in a standard frame.
- R5: The DLC is taken MSB first from bits 15..18 in a standard frame and from bits 35..38 in an extended frame. `warn[2]` is set when the DLC exceeds 8.
- R6: The data field holds N = min(DLC, 8) bytes, or none when `rtr` is 1. Each byte is sent MSB first. Byte i lands in `data[8i+7:8i]`, and bytes that are not received read zero.
- R7: `last_pos` reads 127 until the last DLC bit has been taken. From then on it equals E + 8·N, where E is 18 for a standard frame and 38 for an extended frame.
- R8: The 15 bits from last_pos+1 to last_pos+15 are shifted MSB first into `crc`.
- R9: `ack_ok` is 1 when the bit at last_pos+17 is 0 (dominant).
- R10: Sticky warnings are raised for bad fixed-form bits:
  - `warn[0]`: a recessive SOF;
  - `warn[3]`: a dominant bit at last_pos+16;
  - `warn[4]`: a dominant bit at last_pos+18;
  - `warn[5]`: any dominant bit in last_pos+19..last_pos+25.
- R11: `frame_done` is high for exactly one cycle, the cycle after the strobe of bit last_pos+25. The next strobed bit is taken as bit 0 of a new frame.
- R12: Outputs change only on strobed bits. A strobe at bit 0 clears every field and warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe marking one destuffed frame bit |
| bit_val | input | 1 | Bit value, where 0 is dominant |
| base_id | output | 11 | Base identifier |
| ext_id | output | 18 | Extended identifier |
| full_id | output | 29 | Combined identifier |
| ide | output | 1 | Extended-frame flag |
| rtr | output | 1 | Remote-frame flag |
| dlc | output | 4 | Data length code |
| data | output | 64 | Data bytes, with byte 0 in the low bits |
| crc | output | 15 | Received CRC sequence |
| ack_ok | output | 1 | ACK slot was dominant |
| warn | output | 6 | Sticky form warnings |
| frame_done | output | 1 | End-of-frame pulse |
| last_pos | output | 7 | Index of the last data bit, 127 while unknown |

## Verification
The block has no parameters, so the bench builds it as it stands and sweeps every combination of frame type, RTR and all sixteen DLC codes. That sweep covers every reachable value of `last_pos`, the clamp for DLC codes above 8, and the empty data field of remote frames. Identifiers, data, CRC, ACK and the injected form faults are varied arithmetically from the frame number, and idle gaps of varying length are placed between strobes. Together these exercise the warning flags, field clearing at SOF and holding between frames.

// File: rtl/can_field_parser.sv
module can_field_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_val,
  output logic [10:0] base_id,
  output logic [17:0] ext_id,
  output logic [28:0] full_id,
  output logic        ide,
  output logic        rtr,
  output logic [3:0]  dlc,
  output logic [63:0] data,
  output logic [14:0] crc,
  output logic        ack_ok,
  output logic [5:0]  warn,
  output logic        frame_done,
  output logic [6:0]  last_pos
);

  logic [6:0] idx;
  logic       dlc_done;
  logic [6:0] dlc_end;
  logic [3:0] nbytes;
  logic       in_data;
  logic       in_tail;
  logic [5:0] dpos;
  logic [6:0] rel;

  assign full_id  = {base_id, ext_id};
  assign dlc_end  = ide ? 7'd38 : 7'd18;
  assign nbytes   = rtr ? 4'd0 : ((dlc > 4'd8) ? 4'd8 : dlc);
  assign last_pos = dlc_done ? (dlc_end + {nbytes, 3'b000}) : 7'd127;
  assign in_data  = dlc_done && (idx > dlc_end) && (idx <= last_pos);
  assign in_tail  = dlc_done && (idx > last_pos);
  assign dpos     = 6'(idx - dlc_end - 7'd1);
  assign rel      = idx - last_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      dlc_done   <= 1'b0;
      base_id    <= '0;
      ext_id     <= '0;
      ide        <= 1'b0;
      rtr        <= 1'b0;
      dlc        <= '0;
      data       <= '0;
      crc        <= '0;
      ack_ok     <= 1'b0;
      warn       <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (bit_vld) begin
        idx <= idx + 7'd1;
        if (idx == 7'd0) begin
          dlc_done <= 1'b0;
          base_id  <= '0;
          ext_id   <= '0;
          ide      <= 1'b0;
          rtr      <= 1'b0;
          dlc      <= '0;
          data     <= '0;
          crc      <= '0;
          ack_ok   <= 1'b0;
          warn     <= {5'b0, bit_val};
        end else if (idx <= 7'd11) begin
          base_id <= {base_id[9:0], bit_val};
          if (idx == 7'd11 && (&base_id[9:3]))
            warn[1] <= 1'b1;
        end else if (idx == 7'd12) begin
          rtr <= bit_val;
        end else if (idx == 7'd13) begin
          ide <= bit_val;
        end else if (ide && idx <= 7'd31) begin
          ext_id <= {ext_id[16:0], bit_val};
        end else if (ide && idx == 7'd32) begin
          rtr <= bit_val;
        end else if (!dlc_done && idx > dlc_end - 7'd4 && idx <= dlc_end) begin
          dlc <= {dlc[2:0], bit_val};
          if (idx == dlc_end) begin
            dlc_done <= 1'b1;
            warn[2]  <= ({dlc[2:0], bit_val} > 4'd8);
          end
        end else if (in_data) begin
          data[{dpos[5:3], ~dpos[2:0]}] <= bit_val;
        end else if (in_tail) begin
          if (rel <= 7'd15)
            crc <= {crc[13:0], bit_val};
          else if (rel == 7'd16)
            warn[3] <= warn[3] | ~bit_val;
          else if (rel == 7'd17)
            ack_ok <= ~bit_val;
          else if (rel == 7'd18)
            warn[4] <= warn[4] | ~bit_val;
          else
            warn[5] <= warn[5] | ~bit_val;
          if (rel == 7'd25) begin
            idx        <= '0;
            frame_done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

module can_field_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_vld,
  input logic [28:0] full_id,
  input logic        rtr,
  input logic [3:0]  dlc,
  input logic [63:0] data,
  input logic [14:0] crc,
  input logic [5:0]  warn,
  input logic        frame_done,
  input logic [6:0]  last_pos
);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(bit_vld) && last_pos != 7'd127);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(full_id) && $stable(data) && $stable(crc) && $stable(dlc) && $stable(warn));

  // R5
  dlc_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn[2] |-> dlc > 4'd8);

  // R7
  last_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_pos == 7'd127 || last_pos <= 7'd102);

  // R6
  remote_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtr |-> data == 64'd0);

endmodule

bind can_field_parser can_field_parser_chk chk (.*);

// File: tb/can_field_parser_test.sv
`timescale 1ns/1ps
module can_field_parser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_val = 1'b1;
  logic [10:0] base_id;
  logic [17:0] ext_id;
  logic [28:0] full_id;
  logic ide, rtr, ack_ok, frame_done;
  logic [3:0] dlc;
  logic [63:0] data;
  logic [14:0] crc;
  logic [5:0] warn;
  logic [6:0] last_pos;

  int checks = 0;
  int errors = 0;
  logic fb [0:127];
  int n;

  always #2.5 clk = ~clk;

  can_field_parser uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic b);
    fb[n] = b;
    n++;
  endtask

  task automatic send(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      bit_val = ~bit_val;
    end
    @(negedge clk);
    bit_vld = 1'b1;
    bit_val = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full_id == 0 && dlc == 0 && data == 0 && crc == 0 && warn == 0 && !frame_done
        && !ide && !rtr && !ack_ok, "R1", "reset fields", full_id, 0);
    chk(last_pos == 7'd127, "R1", "reset last_pos", last_pos, 127);

    for (int f = 0; f < 64; f++) begin
      logic        e_ide, e_rtr, b_sof, b_cd, b_ad, b_eof, e_ack;
      logic [3:0]  e_dlc, nb;
      logic [10:0] e_id;
      logic [17:0] e_eid;
      logic [14:0] e_crc;
      logic [63:0] e_data;
      logic [5:0]  e_warn;
      int          dend, last;
      e_ide = f[5];
      e_rtr = f[4];
      e_dlc = 4'(f);
      e_id  = (f % 8 == 3) ? 11'h7F5 : 11'((f * 37 + 5) & 32'h7FF);
      e_eid = e_ide ? 18'((f * 2731 + 11) & 32'h3FFFF) : 18'd0;
      e_crc = 15'((f * 1117 + 3) & 32'h7FFF);
      e_ack = (f % 3 == 0);
      b_sof = (f % 5 == 1);
      b_cd  = (f % 7 == 2);
      b_ad  = (f % 6 == 4);
      b_eof = (f % 9 == 5);
      nb    = e_rtr ? 4'd0 : ((e_dlc > 4'd8) ? 4'd8 : e_dlc);
      dend  = e_ide ? 38 : 18;
      last  = dend + 8 * int'(nb);
      e_data = '0;
      for (int b = 0; b < int'(nb); b++) e_data[8*b +: 8] = 8'((f * 29 + b * 71 + 13) & 255);
      e_warn = {b_eof, b_ad, b_cd, (e_dlc > 4'd8), (e_id[10:4] == 7'h7F), b_sof};

      n = 0;
      put(b_sof);
      for (int k = 10; k >= 0; k--) put(e_id[k]);
      put(e_ide ? 1'b1 : e_rtr);
      put(e_ide);
      if (e_ide) begin
        for (int k = 17; k >= 0; k--) put(e_eid[k]);
        put(e_rtr);
        put(1'b0);
      end
      put(1'b0);
      for (int k = 3; k >= 0; k--) put(e_dlc[k]);
      for (int b = 0; b < int'(nb); b++)
        for (int k = 7; k >= 0; k--) put(e_data[8*b + k]);
      for (int k = 14; k >= 0; k--) put(e_crc[k]);
      put(~b_cd);
      put(~e_ack);
      put(~b_ad);
      for (int k = 0; k < 7; k++) put(!(b_eof && k == f % 7));

      for (int i = 0; i < n; i++) begin
        send(fb[i], (i % 3 == 0) ? (i + f) % 4 : 0);
        if (i == 0) begin
          chk(dlc == 0 && data == 0 && crc == 0 && ext_id == 0, "R12", "cleared at SOF",
              data, 0);
          chk(last_pos == 7'd127, "R7", "last_pos before DLC", last_pos, 127);
        end
        if (i == dend)
          chk(last_pos == 7'(last), "R7", "last_pos after DLC", last_pos, last);
        if (i == n - 2)
          chk(!frame_done, "R11", "done early", frame_done, 0);
      end
      chk(frame_done, "R11", "done pulse", frame_done, 1);
      chk(base_id == e_id, "R2", "base_id", base_id, e_id);
      chk(ide == e_ide, "R3", "ide", ide, e_ide);
      chk(rtr == e_rtr, "R3", "rtr", rtr, e_rtr);
      chk(ext_id == e_eid, "R4", "ext_id", ext_id, e_eid);
      chk(full_id == {e_id, e_eid}, "R4", "full_id", full_id, {e_id, e_eid});
      chk(dlc == e_dlc, "R5", "dlc", dlc, e_dlc);
      chk(data == e_data, "R6", "data", data, e_data);
      chk(last_pos == 7'(last), "R7", "last_pos", last_pos, last);
      chk(crc == e_crc, "R8", "crc", crc, e_crc);
      chk(ack_ok == e_ack, "R9", "ack_ok", ack_ok, e_ack);
      chk(warn == e_warn, "R10", "warn", warn, e_warn);
      @(negedge clk);
      chk(!frame_done, "R11", "done width", frame_done, 0);
      repeat (4) begin
        @(negedge clk);
        bit_val = ~bit_val;
      end
      chk(full_id == {e_id, e_eid} && data == e_data && crc == e_crc && warn == e_warn,
          "R12", "hold between frames", data, e_data);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule